// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces the clamp pulse that a video digitizer uses once per line to re-establish its black level. The pulse can come from an internal timer or from an external pin. The internal timer starts on the trailing edge of the horizontal sync. It waits a programmable number of pixel clocks, then holds the pulse high for a second programmable number of pixel clocks. A polarity bit chooses which sync edge is treated as leading. The trailing edge is always the opposite one.

When the external source is chosen, the pin is synchronized and its polarity is normalized, so the block always drives an active-high pulse. The block also passes out one reference-select flag per channel. Each flag tells the analog clamp switch for that channel to clamp to midscale or to ground.

Both asynchronous inputs, the sync and the external clamp pin, go through a two-flop synchronizer clocked by the pixel clock. The latency of every path is fixed and given in the requirements. An "edge" means a rising edge of `clk`. "Sampling edge" means the first clock edge at which the new input level is present on the pin.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `cfg_hs_pol_i`=0 the rising edge of `hsync_i` is the trailing edge; with `cfg_hs_pol_i`=1 the falling edge is. Only the trailing edge starts the internal timer; the leading edge has no effect.
- R2: In internal mode with placement P (`cfg_place_i`, 0..255), `clamp_o` first goes high after the (4+P)-th edge counting the sampling edge of the trailing level. P=0 therefore starts the pulse on the clock right after trailing-edge detection.
- R3: In internal mode with duration D (`cfg_dur_i`, 1..255), `clamp_o` stays high for exactly D cycles. Placement and duration are taken at the trailing edge that starts the line.
- R4: A duration of 0 produces no pulse for that line.
- R5: A trailing edge that arrives while the timer is waiting or pulsing restarts the placement count for the new line. A pulse already in progress ends: `clamp_o` is low from the 4th edge after the new sampling edge, unless P=0.
- R6: With `cfg_ext_sel_i`=1, `clamp_o` equals the external pin level XOR `cfg_ext_act_low_i` (0 = pin active high, 1 = pin active low). It appears after the 3rd edge counting the pin's sampling edge.
- R7: With `cfg_ext_sel_i`=0, `ext_clamp_i` has no effect on `clamp_o`. With `cfg_ext_sel_i`=1, `hsync_i` has no effect on `clamp_o`.
- R8: `clamp_mid_o[c]` follows `cfg_mid_sel_i[c]` one edge later for each channel c (1 = clamp to midscale, 0 = clamp to ground).
- R9: While `rst` is high, `clamp_o` and `clamp_mid_o` are 0 after every edge, and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Raw horizontal sync, asynchronous |
| ext_clamp_i | input | 1 | External clamp pin, asynchronous |
| cfg_hs_pol_i | input | 1 | Sync polarity: 0 falling edge leads, 1 rising edge leads |
| cfg_ext_sel_i | input | 1 | Clamp source: 1 external pin, 0 internal timer |
| cfg_ext_act_low_i | input | 1 | External pin polarity: 1 active low |
| cfg_place_i | input | CNT_W (8) | Pixel clocks from trailing edge to clamp start |
| cfg_dur_i | input | CNT_W (8) | Clamp width in pixel clocks |
| cfg_mid_sel_i | input | NUM_CH (3) | Per-channel reference select |
| clamp_o | output | 1 | Active-high clamp pulse |
| clamp_mid_o | output | NUM_CH (3) | Per-channel midscale (1) / ground (0) flag |

## Verification
The checker assumes that the synchronizer depth keeps its default. It also assumes that `cfg_ext_sel_i` and the polarity bits change only between edges, so a one-cycle `$past` view of them matches what the output register used. The stimulus changes configuration only at falling clock edges. Before each trace it holds every input steady for longer than the longest possible line (255+255 cycles plus pipeline), so no pulse from an earlier setting leaks into the next window. The random sync and pin patterns use runs of 1 to 50 cycles, with trailing edges often placed inside a running wait or pulse to exercise restarts.

// File: rtl/clamp_gen_pkg.sv
package clamp_gen_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_WAIT  = 2'd1,
    TMR_PULSE = 2'd2
  } tmr_state_t;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cg_trail_detect.sv
module cg_trail_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic lead_rise_i,
  output logic trail_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  // trailing level is high when the leading edge falls, low when it rises
  assign trail_o = (lvl_i != lvl_q) && (lvl_i == ~lead_rise_i);

endmodule

// File: rtl/cg_line_timer.sv
module cg_line_timer
  import clamp_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             pulse_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmr_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TMR_IDLE;
      cnt   <= '0;
      dur_q <= '0;
    end else if (start_i) begin
      dur_q <= dur_i;
      if (dur_i == '0) begin
        st  <= TMR_IDLE;
        cnt <= '0;
      end else if (place_i == '0) begin
        st  <= TMR_PULSE;
        cnt <= dur_i;
      end else begin
        st  <= TMR_WAIT;
        cnt <= place_i;
      end
    end else begin
      unique case (st)
        TMR_WAIT: begin
          if (cnt == ONE) begin
            st  <= TMR_PULSE;
            cnt <= dur_q;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        TMR_PULSE: begin
          if (cnt == ONE) st <= TMR_IDLE;
          cnt <= cnt - ONE;
        end
        default: begin
          st  <= TMR_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign pulse_o = (st == TMR_PULSE);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int CNT_W       = 8,
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_i,
  input  logic              ext_clamp_i,
  input  logic              cfg_hs_pol_i,
  input  logic              cfg_ext_sel_i,
  input  logic              cfg_ext_act_low_i,
  input  logic [CNT_W-1:0]  cfg_place_i,
  input  logic [CNT_W-1:0]  cfg_dur_i,
  input  logic [NUM_CH-1:0] cfg_mid_sel_i,
  output logic              clamp_o,
  output logic [NUM_CH-1:0] clamp_mid_o
);

  localparam int IN_W = 2;

  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] sync_in;
  logic            hs_lvl;
  logic            ext_lvl;
  logic            trail_det;
  logic            tmr_pulse;
  logic            ext_norm;

  assign raw_in = {ext_clamp_i, hsync_i};

  cg_sync #(
    .W      (IN_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_in)
  );

  assign hs_lvl  = sync_in[0];
  assign ext_lvl = sync_in[1];

  cg_trail_detect trail_i (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (hs_lvl),
    .lead_rise_i (cfg_hs_pol_i),
    .trail_o     (trail_det)
  );

  cg_line_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (trail_det),
    .place_i (cfg_place_i),
    .dur_i   (cfg_dur_i),
    .pulse_o (tmr_pulse)
  );

  assign ext_norm = ext_lvl ^ cfg_ext_act_low_i;

  always_ff @(posedge clk) begin
    if (rst) clamp_o <= 1'b0;
    else     clamp_o <= cfg_ext_sel_i ? ext_norm : tmr_pulse;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ref
    always_ff @(posedge clk) begin
      if (rst) clamp_mid_o[ch] <= 1'b0;
      else     clamp_mid_o[ch] <= cfg_mid_sel_i[ch];
    end
  end

endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int CNT_W       = 8,
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_clamp_i,
  input logic              cfg_ext_sel_i,
  input logic              cfg_ext_act_low_i,
  input logic [CNT_W-1:0]  cfg_place_i,
  input logic [CNT_W-1:0]  cfg_dur_i,
  input logic [NUM_CH-1:0] cfg_mid_sel_i,
  input logic              clamp_o,
  input logic [NUM_CH-1:0] clamp_mid_o,
  input logic              trail_det,
  input logic              tmr_pulse
);

  localparam int EXT_LAT = SYNC_STAGES + 1;

  logic [3:0] since_rst;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                  since_rst <= '0;
    else if (since_rst != '1) since_rst <= since_rst + 4'd1;
  end

  // R9: outputs cleared after an edge with reset asserted
  always_ff @(posedge clk) begin
    if (rst_q == 1'b1) begin
      p_reset_clear_r9: assert (clamp_o == 1'b0 && clamp_mid_o == '0)
        else $error("reset did not clear outputs");
    end
  end

  p_ext_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'(EXT_LAT) && $past(cfg_ext_sel_i))
      |-> clamp_o == ($past(ext_clamp_i, EXT_LAT) ^ $past(cfg_ext_act_low_i)));

  p_mid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd1) |-> clamp_mid_o == $past(cfg_mid_sel_i));

  p_zero_dur_r4: assert property (@(posedge clk) disable iff (rst)
    (trail_det && cfg_dur_i == '0) |=> !tmr_pulse);

  p_restart_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (trail_det && cfg_place_i != '0) |=> !tmr_pulse);

  p_start_now_r2: assert property (@(posedge clk) disable iff (rst)
    (trail_det && cfg_place_i == '0 && cfg_dur_i != '0) |=> tmr_pulse);

endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(
  .CNT_W       (CNT_W),
  .NUM_CH      (NUM_CH),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .clk               (clk),
  .rst               (rst),
  .ext_clamp_i       (ext_clamp_i),
  .cfg_ext_sel_i     (cfg_ext_sel_i),
  .cfg_ext_act_low_i (cfg_ext_act_low_i),
  .cfg_place_i       (cfg_place_i),
  .cfg_dur_i         (cfg_dur_i),
  .cfg_mid_sel_i     (cfg_mid_sel_i),
  .clamp_o           (clamp_o),
  .clamp_mid_o       (clamp_mid_o),
  .trail_det         (trail_det),
  .tmr_pulse         (tmr_pulse)
);

// File: tb/clamp_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module clamp_pulse_gen_tb_top;

  localparam int CNT_W  = 8;
  localparam int NUM_CH = 3;
  localparam int MAXN   = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hsync_i = 1'b0;
  logic              ext_clamp_i = 1'b0;
  logic              cfg_hs_pol_i = 1'b0;
  logic              cfg_ext_sel_i = 1'b0;
  logic              cfg_ext_act_low_i = 1'b0;
  logic [CNT_W-1:0]  cfg_place_i = '0;
  logic [CNT_W-1:0]  cfg_dur_i = '0;
  logic [NUM_CH-1:0] cfg_mid_sel_i = '0;
  logic              clamp_o;
  logic [NUM_CH-1:0] clamp_mid_o;

  int checks = 0;
  int errors = 0;

  bit lvl_h [MAXN];
  bit lvl_e [MAXN];
  bit trace [MAXN];

  always #4 clk = ~clk;

  clamp_pulse_gen #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) dut_i (
    .clk               (clk),
    .rst               (rst),
    .hsync_i           (hsync_i),
    .ext_clamp_i       (ext_clamp_i),
    .cfg_hs_pol_i      (cfg_hs_pol_i),
    .cfg_ext_sel_i     (cfg_ext_sel_i),
    .cfg_ext_act_low_i (cfg_ext_act_low_i),
    .cfg_place_i       (cfg_place_i),
    .cfg_dur_i         (cfg_dur_i),
    .cfg_mid_sel_i     (cfg_mid_sel_i),
    .clamp_o           (clamp_o),
    .clamp_mid_o       (clamp_mid_o)
  );

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // expected internal-mode clamp at sample i (R1..R5)
  function automatic bit exp_int(int i, bit h0, bit pol, int p, int d);
    int  t_last = -1;
    bit  prev;
    for (int t = 0; t <= i - 4; t++) begin
      prev = (t == 0) ? h0 : lvl_h[t-1];
      if (lvl_h[t] != prev && lvl_h[t] == !pol) t_last = t;
    end
    if (t_last < 0 || d == 0) return 1'b0;
    return (i >= t_last + 4 + p) && (i < t_last + 4 + p + d);
  endfunction

  // expected external-mode clamp at sample i (R6)
  function automatic bit exp_ext(int i, bit e0, bit act_low);
    if (i < 3) return e0 ^ act_low;
    return lvl_e[i-3] ^ act_low;
  endfunction

  task automatic fill(bit hs, int from, int to, bit v);
    for (int i = from; i < to; i++) begin
      if (hs) lvl_h[i] = v;
      else    lvl_e[i] = v;
    end
  endtask

  task automatic fill_rand(bit hs, int n, bit start);
    bit cur = start;
    int i = 0;
    while (i < n) begin
      int len = 1 + int'($urandom % 50);
      fill(hs, i, (i + len > n) ? n : i + len, cur);
      i += len;
      cur = !cur;
    end
  endtask

  task automatic run_trace(int n, bit h0, bit e0, string tag);
    bit want;
    bit bad = 1'b0;
    int bad_i = 0;
    bit bad_act = 1'b0;
    bit bad_exp = 1'b0;
    @(negedge clk);
    hsync_i = h0;
    ext_clamp_i = e0;
    repeat (600) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trace[i] = clamp_o;
      hsync_i = lvl_h[i];
      ext_clamp_i = lvl_e[i];
    end
    for (int i = 0; i < n; i++) begin
      if (cfg_ext_sel_i) want = exp_ext(i, e0, cfg_ext_act_low_i);
      else want = exp_int(i, h0, cfg_hs_pol_i, int'(cfg_place_i), int'(cfg_dur_i));
      if (!bad && trace[i] != want) begin
        bad = 1'b1; bad_i = i; bad_act = trace[i]; bad_exp = want;
      end
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: clamp_o at sample %0d actual=%0b expected=%0b (place=%0d dur=%0d)",
               tag, bad_i, bad_act, bad_exp, cfg_place_i, cfg_dur_i);
    end
  endtask

  task automatic set_int(bit pol, int p, int d);
    @(negedge clk);
    cfg_ext_sel_i = 1'b0;
    cfg_hs_pol_i  = pol;
    cfg_place_i   = CNT_W'(p);
    cfg_dur_i     = CNT_W'(d);
  endtask

  task automatic check_mid(logic [NUM_CH-1:0] v);
    @(negedge clk);
    cfg_mid_sel_i = v;
    @(negedge clk);
    checks++;
    if (clamp_mid_o !== v) begin
      errors++;
      $display("FAIL R8: clamp_mid_o actual=%b expected=%b", clamp_mid_o, v);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    cfg_mid_sel_i = '1;
    repeat (5) @(negedge clk);
    checks++;
    if (clamp_o !== 1'b0 || clamp_mid_o !== '0) begin
      errors++;
      $display("FAIL R9: actual clamp=%b mid=%b expected clamp=0 mid=000", clamp_o, clamp_mid_o);
    end
    @(negedge clk);
    rst = 1'b0;
    cfg_mid_sel_i = '0;

    // R1 R2 R3: falling edge leads, rising is trailing, recommended values
    set_int(1'b0, 4, 40);
    fill(1'b1, 0, MAXN, 1'b1); fill(1'b1, 5, 15, 1'b0); fill(1'b0, 0, MAXN, 1'b0);
    run_trace(100, 1'b1, 1'b0, "R1_R2_R3 pol0");

    // R1: rising edge leads, falling is trailing
    set_int(1'b1, 4, 40);
    fill(1'b1, 0, MAXN, 1'b0); fill(1'b1, 5, 15, 1'b1);
    run_trace(100, 1'b0, 1'b0, "R1 pol1");

    // R2: zero placement, one-cycle pulse
    set_int(1'b1, 0, 1);
    run_trace(60, 1'b0, 1'b0, "R2 place0");

    // R3: maximum placement and duration
    set_int(1'b1, 255, 255);
    run_trace(560, 1'b0, 1'b0, "R3 max");

    // R4: zero duration
    set_int(1'b1, 4, 0);
    run_trace(100, 1'b0, 1'b0, "R4 dur0");

    // R5: new line during pulse, then during wait
    set_int(1'b1, 4, 40);
    fill(1'b1, 0, MAXN, 1'b0); fill(1'b1, 5, 15, 1'b1); fill(1'b1, 30, 35, 1'b1);
    run_trace(140, 1'b0, 1'b0, "R5 in pulse");
    set_int(1'b1, 30, 10);
    fill(1'b1, 0, MAXN, 1'b0); fill(1'b1, 5, 15, 1'b1); fill(1'b1, 20, 25, 1'b1);
    run_trace(140, 1'b0, 1'b0, "R5 in wait");

    // R7: external pin ignored in internal mode
    set_int(1'b0, 6, 12);
    fill_rand(1'b1, 400, 1'b1); fill_rand(1'b0, 400, 1'b0);
    run_trace(400, 1'b1, 1'b0, "R7 ext ignored");

    // R6 R7: external source, both polarities, hsync toggling
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cfg_ext_sel_i = 1'b1;
      cfg_ext_act_low_i = k[0];
      fill_rand(1'b1, 300, 1'b0); fill_rand(1'b0, 300, 1'b1);
      run_trace(300, 1'b0, 1'b1, k == 0 ? "R6_R7 ext high" : "R6_R7 ext low");
    end

    // R8: per-channel reference selects
    check_mid(3'b001);
    check_mid(3'b110);
    check_mid(3'b101);
    check_mid(3'b000);

    // R1 R2 R3 R5: random lines and settings
    for (int k = 0; k < 16; k++) begin
      bit pol = 1'($urandom % 2);
      set_int(pol, int'($urandom % 41), int'($urandom % 41));
      fill_rand(1'b1, 400, !pol);
      fill_rand(1'b0, 400, 1'b0);
      run_trace(400, !pol, 1'b0, "R2_R3_R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule